// File: doc/BRIEF.md
# Multi-Size Forward Transform Butterfly Front End

This block is the even/odd decomposition stage that sits in front of a one-dimensional forward integer DCT of the kind used by block-based video encoders. It supports transforms of 4, 8, 16 and 32 points. An N-point transform reduces to two N/2-point transforms after a butterfly step. At each level the input vector is folded into a sum half and a difference half. The sum half is folded again at the next smaller level, down to the 4-point level.

One vector of up to 32 signed samples enters per cycle together with a 2-bit size code. The block runs the butterfly levels that the chosen size needs, always in descending order, and lets the data pass through the levels it does not need. It delivers the final even pair of the 4-point level and the difference vector of every level, all aligned in the same output cycle. A per-level flag tells the downstream multiply networks which difference vectors carry data. Every level adds one bit of headroom and one register stage, so all sizes have the same latency.

Top module: `dct_bf_front`

## Requirements
- R1: The size code selects the transform length: 2'b00 = 4, 2'b01 = 8, 2'b10 = 16, 2'b11 = 32 points. Input lanes with index at or above the selected length have no effect on any output.
- R2: A level of length M maps its inputs x to sum[i] = x[i] + x[M-1-i] and diff[i] = x[i] - x[M-1-i], for i = 0 .. M/2-1. Lane i of each port occupies bits [i*W +: W], where W is that port's lane width.
- R3: Levels are applied in the order 32, 16, 8, 4, and each used level consumes the sum half of the previous used level. A 4-point transform uses only the 4-point level, an 8-point transform uses 8 then 4, a 16-point transform uses 16, 8, 4, and a 32-point transform uses all four levels. An unused level passes its lower lanes through unchanged.
- R4: Each level widens its lanes by one bit, so lane widths are DW+1 (32-level differences), DW+2 (16), DW+3 (8) and DW+4 (4-level sums and differences). Full-scale inputs of either sign never overflow.
- R5: A vector accepted with in_vld high appears on the outputs with out_vld high exactly four clock cycles later, for every size. out_vld is low in every cycle that has no matching accepted input.
- R6: When out_vld is high, flag_d32, flag_d16 and flag_d8 are high exactly when the 32-, 16- and 8-point levels were used for that vector. All flags are low while out_vld is low.
- R7: The difference vector of an unused level reads as all zeros.
- R8: After reset, out_vld, all flags and all data outputs are zero.
- R9: Vectors may arrive in consecutive cycles with different size codes, and each leaves four cycles after it entered without mixing with its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input vector valid |
| size_code | input | 2 | Transform length code |
| samples | input | 32*DW | Input samples, lane i at [i*DW +: DW] |
| out_vld | output | 1 | Output vector valid |
| flag_d32 | output | 1 | 32-point difference vector carries data |
| flag_d16 | output | 1 | 16-point difference vector carries data |
| flag_d8 | output | 1 | 8-point difference vector carries data |
| sum4 | output | 2*(DW+4) | Sum pair of the 4-point level |
| diff4 | output | 2*(DW+4) | Difference pair of the 4-point level |
| diff8 | output | 4*(DW+3) | Difference vector of the 8-point level |
| diff16 | output | 8*(DW+2) | Difference vector of the 16-point level |
| diff32 | output | 16*(DW+1) | Difference vector of the 32-point level |

## Verification
The butterfly cascade is driven with a lane ramp, with which a swapped lane mirror or a wrong subtraction order shows as a sign or index error. Pseudo-random vectors at each of the four sizes show whether the right levels are switched in for each code. Each short size is sent twice with different junk in the unused upper lanes, so any leak from those lanes changes a result. Full-scale vectors of equal and of opposite sign push the sums and differences to their largest magnitudes and expose a lost headroom bit. A burst of back-to-back vectors with mixed size codes checks that data, size and flags stay aligned through the pipeline.

// File: rtl/dct_bf_pkg.sv
package dct_bf_pkg;

  localparam int NLANE = 32;

  localparam logic [1:0] SZ_4  = 2'd0;
  localparam logic [1:0] SZ_8  = 2'd1;
  localparam logic [1:0] SZ_16 = 2'd2;
  localparam logic [1:0] SZ_32 = 2'd3;

  // Does the level of length 2**lg take part for the given size code?
  function automatic logic level_used(input logic [1:0] sz, input int unsigned lg);
    logic r;
    case (lg)
      5:       r = (sz == SZ_32);
      4:       r = sz[1];
      3:       r = (sz != SZ_4);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dct_bf_rst_sync.sv
module dct_bf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dct_bf_level.sv
module dct_bf_level #(
  parameter int M  = 32,
  parameter int IW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vld_i,
  input  logic                      use_i,
  input  logic [1:0]                sz_i,
  input  logic [M*IW-1:0]           din,
  output logic                      vld_o,
  output logic [1:0]                sz_o,
  output logic [(M/2)*(IW+1)-1:0]   sum_o,
  output logic [(M/2)*(IW+1)-1:0]   dif_o
);

  localparam int OW = IW + 1;
  localparam int H  = M / 2;

  logic [H*OW-1:0] sum_d;
  logic [H*OW-1:0] dif_d;

  for (genvar i = 0; i < H; i++) begin : g_lane
    logic signed [IW-1:0] lo;
    logic signed [IW-1:0] hi;
    logic signed [OW-1:0] lo_x;
    logic signed [OW-1:0] hi_x;

    assign lo   = din[i*IW +: IW];
    assign hi   = din[(M-1-i)*IW +: IW];
    assign lo_x = {lo[IW-1], lo};
    assign hi_x = {hi[IW-1], hi};

    assign sum_d[i*OW +: OW] = use_i ? (lo_x + hi_x) : lo_x;
    assign dif_d[i*OW +: OW] = use_i ? (lo_x - hi_x) : '0;
  end

  logic              vld_q;
  logic [1:0]        sz_q;
  logic [H*OW-1:0]   sum_q;
  logic [H*OW-1:0]   dif_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sz_q  <= 2'b00;
      sum_q <= '0;
      dif_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        sz_q  <= sz_i;
        sum_q <= sum_d;
        dif_q <= dif_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign sz_o  = sz_q;
  assign sum_o = sum_q;
  assign dif_o = dif_q;

endmodule

// File: rtl/dct_bf_delay.sv
module dct_bf_delay #(
  parameter int W = 16,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [D-1:0] en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar j = 0; j < D; j++) begin : g_st
    logic [W-1:0] r;
    logic [W-1:0] nx;

    if (j == 0) begin : g_head
      assign nx = d;
    end else begin : g_body
      assign nx = g_st[j-1].r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (en[j]) begin
        r <= nx;
      end
    end
  end

  assign q = g_st[D-1].r;

endmodule

// File: rtl/dct_bf_front.sv
module dct_bf_front
  import dct_bf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [1:0]            size_code,
  input  logic [NLANE*DW-1:0]   samples,
  output logic                  out_vld,
  output logic                  flag_d32,
  output logic                  flag_d16,
  output logic                  flag_d8,
  output logic [2*(DW+4)-1:0]   sum4,
  output logic [2*(DW+4)-1:0]   diff4,
  output logic [4*(DW+3)-1:0]   diff8,
  output logic [8*(DW+2)-1:0]   diff16,
  output logic [16*(DW+1)-1:0]  diff32
);

  localparam int W1 = DW + 1;
  localparam int W2 = DW + 2;
  localparam int W3 = DW + 3;
  localparam int W4 = DW + 4;

  logic rst_s;

  dct_bf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  logic              v1, v2, v3, v4;
  logic [1:0]        s1, s2, s3, s4;
  logic [16*W1-1:0]  sum_l32, dif_l32;
  logic [8*W2-1:0]   sum_l16, dif_l16;
  logic [4*W3-1:0]   sum_l8,  dif_l8;
  logic [2*W4-1:0]   sum_l4,  dif_l4;

  dct_bf_level #(.M(32), .IW(DW)) u_l32 (
    .clk   (clk),
    .rst_n (rst_s),
    .vld_i (in_vld),
    .use_i (level_used(size_code, 5)),
    .sz_i  (size_code),
    .din   (samples),
    .vld_o (v1),
    .sz_o  (s1),
    .sum_o (sum_l32),
    .dif_o (dif_l32)
  );

  dct_bf_level #(.M(16), .IW(W1)) u_l16 (
    .clk   (clk),
    .rst_n (rst_s),
    .vld_i (v1),
    .use_i (level_used(s1, 4)),
    .sz_i  (s1),
    .din   (sum_l32),
    .vld_o (v2),
    .sz_o  (s2),
    .sum_o (sum_l16),
    .dif_o (dif_l16)
  );

  dct_bf_level #(.M(8), .IW(W2)) u_l8 (
    .clk   (clk),
    .rst_n (rst_s),
    .vld_i (v2),
    .use_i (level_used(s2, 3)),
    .sz_i  (s2),
    .din   (sum_l16),
    .vld_o (v3),
    .sz_o  (s3),
    .sum_o (sum_l8),
    .dif_o (dif_l8)
  );

  dct_bf_level #(.M(4), .IW(W3)) u_l4 (
    .clk   (clk),
    .rst_n (rst_s),
    .vld_i (v3),
    .use_i (level_used(s3, 2)),
    .sz_i  (s3),
    .din   (sum_l8),
    .vld_o (v4),
    .sz_o  (s4),
    .sum_o (sum_l4),
    .dif_o (dif_l4)
  );

  // Align the early difference vectors with the 4-point level output.
  dct_bf_delay #(.W(16*W1), .D(3)) u_dly32 (
    .clk   (clk),
    .rst_n (rst_s),
    .en    ({v3, v2, v1}),
    .d     (dif_l32),
    .q     (diff32)
  );

  dct_bf_delay #(.W(8*W2), .D(2)) u_dly16 (
    .clk   (clk),
    .rst_n (rst_s),
    .en    ({v3, v2}),
    .d     (dif_l16),
    .q     (diff16)
  );

  dct_bf_delay #(.W(4*W3), .D(1)) u_dly8 (
    .clk   (clk),
    .rst_n (rst_s),
    .en    (v3),
    .d     (dif_l8),
    .q     (diff8)
  );

  assign sum4     = sum_l4;
  assign diff4    = dif_l4;
  assign out_vld  = v4;
  assign flag_d32 = v4 & level_used(s4, 5);
  assign flag_d16 = v4 & level_used(s4, 4);
  assign flag_d8  = v4 & level_used(s4, 3);

endmodule

// File: rtl/dct_bf_chk.sv
module dct_bf_chk #(
  parameter int DW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_vld,
  input logic [1:0]            size_code,
  input logic                  out_vld,
  input logic                  flag_d32,
  input logic                  flag_d16,
  input logic                  flag_d8,
  input logic [4*(DW+3)-1:0]   diff8,
  input logic [8*(DW+2)-1:0]   diff16,
  input logic [16*(DW+1)-1:0]  diff32
);

  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 3'd0;
    end else if (since_rst != 3'd4) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_vld == $past(in_vld, 4)));

  p_flag32_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && out_vld) |-> (flag_d32 == ($past(size_code, 4) == 2'b11)));

  p_flag_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_d32 |-> flag_d16);

  p_flag_nest8_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_d16 |-> flag_d8);

  p_flag_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_d8 |-> out_vld);

  p_zero32_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !flag_d32) |-> (diff32 == '0));

  p_zero16_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !flag_d16) |-> (diff16 == '0));

  p_zero8_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !flag_d8) |-> (diff8 == '0));

endmodule

bind dct_bf_front dct_bf_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .size_code (size_code),
  .out_vld   (out_vld),
  .flag_d32  (flag_d32),
  .flag_d16  (flag_d16),
  .flag_d8   (flag_d8),
  .diff8     (diff8),
  .diff16    (diff16),
  .diff32    (diff32)
);

// File: tb/sim_dct_bf_front.sv
`timescale 1ns/1ps
module sim_dct_bf_front;

  localparam int DW = 16;
  localparam int W1 = DW + 1;
  localparam int W2 = DW + 2;
  localparam int W3 = DW + 3;
  localparam int W4 = DW + 4;

  logic                 clk;
  logic                 rst_n;
  logic                 in_vld;
  logic [1:0]           size_code;
  logic [32*DW-1:0]     samples;
  logic                 out_vld, flag_d32, flag_d16, flag_d8;
  logic [2*W4-1:0]      sum4, diff4;
  logic [4*W3-1:0]      diff8;
  logic [8*W2-1:0]      diff16;
  logic [16*W1-1:0]     diff32;

  dct_bf_front #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .size_code(size_code),
    .samples(samples), .out_vld(out_vld), .flag_d32(flag_d32),
    .flag_d16(flag_d16), .flag_d8(flag_d8), .sum4(sum4), .diff4(diff4),
    .diff8(diff8), .diff16(diff16), .diff32(diff32)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  int e_s4[2], e_d4[2], e_d8[4], e_d16[8], e_d32[16];

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gen(int mode, int lane);
    int v;
    case (mode)
      0: return lane * 997 - 15000;
      1: return 32767;
      2: return (lane < 16) ? 32767 : -32768;
      3: return (lane % 2 == 0) ? -32768 : 32767;
      default: begin
        v = mode * 1103515245 + lane * 12345 + lane * lane * 977 + 7;
        v = v ^ (v >>> 13);
        return int'(shortint'(v));
      end
    endcase
  endfunction

  function automatic int len_of(int sz);
    return 4 << sz;
  endfunction

  // Reference cascade built from R2/R3/R7.
  task automatic run_model(int mode, int sz);
    int cur[32];
    int od[16];
    int m;
    bit used;
    for (int l = 0; l < 32; l++) cur[l] = gen(mode, l);
    for (int lv = 0; lv < 4; lv++) begin
      m = 32 >> lv;
      used = (lv == 3) || (sz >= 3 - lv);
      for (int i = 0; i < m / 2; i++) begin
        od[i] = used ? cur[i] - cur[m-1-i] : 0;
        cur[i] = used ? cur[i] + cur[m-1-i] : cur[i];
      end
      for (int i = 0; i < m / 2; i++) begin
        case (lv)
          0: e_d32[i] = od[i];
          1: e_d16[i] = od[i];
          2: e_d8[i]  = od[i];
          default: e_d4[i] = od[i];
        endcase
      end
    end
    e_s4[0] = cur[0];
    e_s4[1] = cur[1];
  endtask

  task automatic put_vector(int mode, int sz, int junk);
    for (int l = 0; l < 32; l++) begin
      if (l >= len_of(sz) && junk != 0)
        samples[l*DW +: DW] = 16'(gen(mode + junk, l));
      else
        samples[l*DW +: DW] = 16'(gen(mode, l));
    end
    size_code = 2'(sz);
    in_vld = 1'b1;
  endtask

  task automatic compare_out(string req, int mode, int sz);
    run_model(mode, sz);
    check("R5", {req, " out_vld"}, int'(out_vld), 1);
    check("R6", {req, " flag_d32"}, int'(flag_d32), int'(sz == 3));
    check("R6", {req, " flag_d16"}, int'(flag_d16), int'(sz >= 2));
    check("R6", {req, " flag_d8"}, int'(flag_d8), int'(sz >= 1));
    for (int i = 0; i < 2; i++) begin
      check(req, $sformatf("sum4[%0d]", i), int'($signed(sum4[i*W4 +: W4])), e_s4[i]);
      check(req, $sformatf("diff4[%0d]", i), int'($signed(diff4[i*W4 +: W4])), e_d4[i]);
    end
    for (int i = 0; i < 4; i++)
      check(req, $sformatf("diff8[%0d]", i), int'($signed(diff8[i*W3 +: W3])), e_d8[i]);
    for (int i = 0; i < 8; i++)
      check(req, $sformatf("diff16[%0d]", i), int'($signed(diff16[i*W2 +: W2])), e_d16[i]);
    for (int i = 0; i < 16; i++)
      check(req, $sformatf("diff32[%0d]", i), int'($signed(diff32[i*W1 +: W1])), e_d32[i]);
  endtask

  // One vector, latency checked at cycle 3 (low) and 4 (high, data).
  task automatic t_single(string req, int mode, int sz, int junk);
    @(negedge clk);
    put_vector(mode, sz, junk);
    @(posedge clk);
    @(negedge clk);
    in_vld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5", {req, " early out_vld"}, int'(out_vld), 0);
    @(posedge clk);
    @(negedge clk);
    compare_out(req, mode, sz);
    @(posedge clk);
    @(negedge clk);
    check("R5", {req, " trailing out_vld"}, int'(out_vld), 0);
    check("R6", {req, " trailing flag_d8"}, int'(flag_d8), 0);
  endtask

  task automatic t_reset;
    check("R8", "out_vld", int'(out_vld), 0);
    check("R8", "flags", int'({flag_d32, flag_d16, flag_d8}), 0);
    check("R8", "sum4 zero", int'(sum4 == '0), 1);
    check("R8", "diff32 zero", int'(diff32 == '0), 1);
  endtask

  task automatic t_ramp;
    t_single("R2 ramp32", 0, 3, 0);
    t_single("R3 ramp16", 0, 2, 0);
  endtask

  task automatic t_sizes;
    t_single("R3 rand32", 21, 3, 0);
    t_single("R3 rand16", 22, 2, 0);
    t_single("R3 rand8", 23, 1, 0);
    t_single("R3 rand4", 24, 0, 0);
  endtask

  task automatic t_ignored;
    t_single("R1 junkA sz4", 31, 0, 50);
    t_single("R1 junkB sz4", 31, 0, 90);
    t_single("R1 junkA sz8", 32, 1, 50);
    t_single("R1 junkB sz8", 32, 1, 90);
    t_single("R1 junkA sz16", 33, 2, 50);
    t_single("R1 junkB sz16", 33, 2, 90);
  endtask

  task automatic t_extremes;
    t_single("R4 allmax32", 1, 3, 0);
    t_single("R4 split32", 2, 3, 0);
    t_single("R4 alt32", 3, 3, 0);
    t_single("R4 alt8", 3, 1, 0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    put_vector(41, 3, 0);
    @(negedge clk);
    put_vector(42, 0, 60);
    @(negedge clk);
    put_vector(43, 2, 60);
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    compare_out("R9 stream0", 41, 3);
    @(negedge clk);
    compare_out("R9 stream1", 42, 0);
    @(negedge clk);
    compare_out("R9 stream2", 43, 2);
    @(negedge clk);
    check("R9", "stream end out_vld", int'(out_vld), 0);
  endtask

  task automatic t_bubble;
    @(negedge clk);
    put_vector(51, 1, 0);
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    put_vector(52, 3, 0);
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    compare_out("R9 bubble0", 51, 1);
    @(negedge clk);
    check("R5", "bubble gap out_vld", int'(out_vld), 0);
    @(negedge clk);
    compare_out("R9 bubble1", 52, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL R5 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_vld = 1'b0;
    size_code = 2'b00;
    samples = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_ramp();
    t_sizes();
    t_ignored();
    t_extremes();
    t_stream();
    t_bubble();
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule